// File: doc/BRIEF.md
# Packed SIMD Rounding Right Shifter

This block shifts every element of a 128-bit packed vector to the right and rounds the result half-up. The round bit is the last bit shifted out of the element. Elements are 8, 16, 32 or 64 bits wide. Each element is treated as unsigned, with zero fill, or as signed, with the sign bit replicated. The shift count for each element comes from one of two places. In register mode it is the matching element of a second vector. In immediate mode it is one small immediate that every element shares.

The datapath is purely combinational. An optional output register adds one cycle of latency. A valid bit travels with the data through that register. When the register is disabled by parameter, the result and the valid bit pass straight through. An instruction decoder in front of the block drives the size, mode and source selects. The result goes back to the vector register file.

Top module: `rshift_round_simd`

## Requirements
- R1: `esize` codes 0, 1, 2 and 3 select elements of 8, 16, 32 and 64 bits. Element i of width W occupies bits [i*W +: W] of every vector port.
- R2: When `use_imm`=0, an element's shift count is the low log2(W) bits of the matching element of `amt_vec`, read as unsigned. The count is therefore taken modulo W.
- R3: When `use_imm`=1, every element uses the low log2(W) bits of `imm_amt` as its count. The upper bits of `imm_amt` are ignored.
- R4: An element whose count is zero is output unchanged.
- R5: For a nonzero count s, the element result is (x shifted right by s) plus bit s-1 of x. The sum is truncated to W bits. For example, logical 0xFF shifted by 1 gives 0x80.
- R6: `arith`=0 fills with zeros from the top. `arith`=1 replicates the sign bit. For example, the 8-bit arithmetic shift of 0xFF by 1 gives 0x00.
- R7: With REG_OUT=1, `out_valid` and `res_vec` appear exactly one clock after the `in_valid` cycle that carried the inputs. `out_valid` is low after a cycle without `in_valid`.
- R8: With REG_OUT=1, `res_vec` holds its value through cycles in which `in_valid` is low, whatever the other inputs do.
- R9: A synchronous active-high `rst` clears `out_valid` and `res_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry an operation |
| src_vec | input | 128 | Packed elements to shift |
| amt_vec | input | 128 | Per-element shift counts (register mode) |
| imm_amt | input | 6 | Shared shift count (immediate mode) |
| esize | input | 2 | Element size code |
| arith | input | 1 | 1 = signed shift, 0 = unsigned shift |
| use_imm | input | 1 | 1 = immediate count, 0 = per-element count |
| out_valid | output | 1 | Result valid |
| res_vec | output | 128 | Packed rounded results |

## Verification
Two cases are the hardest to reach from the ports. One is an element whose rounding add wraps within the element. The other is a register-mode count whose upper bits are set but reduce to a small value modulo W. Random data seldom produces the all-ones and minimum signed patterns that expose either case. The stimulus therefore mixes seeded random vectors with directed vectors for every size and both fill modes. The directed vectors use all-ones elements, the minimum signed value, and counts of 0 and W-1. They also use count elements with their high bits set, and immediates with their unused upper bits set.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int VEC_W     = 128;
  localparam int MAX_ELEM  = 64;
  localparam int IMM_W     = $clog2(MAX_ELEM);
  localparam int N_SIZES   = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } elem_size_e;
endpackage

// File: rtl/rsr_lane.sv
// One element: shift right by sh, then add the last bit shifted out.
module rsr_lane #(
  parameter int W  = 8,
  localparam int LG = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  logic [LG-1:0] sh,
  input  logic          arith,
  output logic [W-1:0]  y
);
  logic signed [W-1:0] xs;
  logic [W-1:0]        shifted;
  logic                rnd;

  assign xs = x;

  always_comb begin
    if (arith) shifted = W'(xs >>> sh);
    else       shifted = x >> sh;
    // a zero count contributes no round bit, so the element passes through
    rnd = (sh != '0) && x[sh - 1'b1];
    y   = shifted + {{(W-1){1'b0}}, rnd};
  end
endmodule

// File: rtl/rsr_size_slice.sv
// All elements of one width across the vector.
module rsr_size_slice #(
  parameter int VW    = 128,
  parameter int W     = 8,
  parameter int IMMW  = 6,
  localparam int LG    = $clog2(W),
  localparam int LANES = VW / W
) (
  input  logic [VW-1:0]   src,
  input  logic [VW-1:0]   amt,
  input  logic [IMMW-1:0] imm,
  input  logic            arith,
  input  logic            use_imm,
  output logic [VW-1:0]   res
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LG-1:0] cnt;
    assign cnt = use_imm ? imm[LG-1:0] : amt[i*W +: LG];
    rsr_lane #(.W(W)) u_lane (
      .x     (src[i*W +: W]),
      .sh    (cnt),
      .arith (arith),
      .y     (res[i*W +: W])
    );
  end
endmodule

// File: rtl/rsr_out_stage.sv
// Optional output register; combinational pass-through when REG_OUT=0.
module rsr_out_stage #(
  parameter int VW      = 128,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          d_valid,
  input  logic [VW-1:0] d,
  output logic          q_valid,
  output logic [VW-1:0] q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q_valid <= 1'b0;
        q       <= '0;
      end else begin
        q_valid <= d_valid;
        if (d_valid) q <= d;
      end
    end
  end else begin : g_comb
    assign q_valid = d_valid;
    assign q       = d;
  end
endmodule

// File: rtl/rshift_round_simd.sv
module rshift_round_simd #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [rsr_pkg::VEC_W-1:0] src_vec,
  input  logic [rsr_pkg::VEC_W-1:0] amt_vec,
  input  logic [rsr_pkg::IMM_W-1:0] imm_amt,
  input  logic [1:0]                esize,
  input  logic                      arith,
  input  logic                      use_imm,
  output logic                      out_valid,
  output logic [rsr_pkg::VEC_W-1:0] res_vec
);
  import rsr_pkg::*;

  logic [VEC_W-1:0] by_size [N_SIZES];
  logic [VEC_W-1:0] sel;
  elem_size_e       sz;

  assign sz = elem_size_e'(esize);

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    rsr_size_slice #(.VW(VEC_W), .W(8 << g), .IMMW(IMM_W)) u_slice (
      .src     (src_vec),
      .amt     (amt_vec),
      .imm     (imm_amt),
      .arith   (arith),
      .use_imm (use_imm),
      .res     (by_size[g])
    );
  end

  always_comb begin
    unique case (sz)
      SZ_BYTE: sel = by_size[0];
      SZ_HALF: sel = by_size[1];
      SZ_WORD: sel = by_size[2];
      default: sel = by_size[3];
    endcase
  end

  rsr_out_stage #(.VW(VEC_W), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d       (sel),
    .q_valid (out_valid),
    .q       (res_vec)
  );
endmodule

// File: rtl/rsr_chk.sv
module rsr_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [127:0] src_vec,
  input logic [5:0]   imm_amt,
  input logic [1:0]   esize,
  input logic         arith,
  input logic         use_imm,
  input logic         out_valid,
  input logic [127:0] res_vec
);
  if (REG_OUT) begin : g_seq
    // R9
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && res_vec == '0));
    // R7
    latency_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    // R7
    idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(res_vec));
    // R4
    zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && use_imm && imm_amt == 6'd0) |=> res_vec == $past(src_vec));
    // R6
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && use_imm && !arith && esize == 2'd3 && imm_amt >= 6'd2)
        |=> (!res_vec[63] && !res_vec[127]));
  end else begin : g_comb
    always_comb begin
      // R7
      pass_valid_chk: assert (in_valid == out_valid);
    end
  end
endmodule

bind rshift_round_simd rsr_chk #(.REG_OUT(REG_OUT)) u_rsr_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
  .imm_amt(imm_amt), .esize(esize), .arith(arith), .use_imm(use_imm),
  .out_valid(out_valid), .res_vec(res_vec)
);

// File: tb/rshift_round_simd_bench.sv
`timescale 1ns/1ps
module rshift_round_simd_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] src_vec = '0;
  logic [127:0] amt_vec = '0;
  logic [5:0]   imm_amt = '0;
  logic [1:0]   esize = '0;
  logic         arith = 1'b0;
  logic         use_imm = 1'b0;
  logic         out_valid;
  logic [127:0] res_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rshift_round_simd u_rshift_round_simd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .amt_vec(amt_vec), .imm_amt(imm_amt), .esize(esize), .arith(arith),
    .use_imm(use_imm), .out_valid(out_valid), .res_vec(res_vec)
  );

  function automatic logic [127:0] model(input logic [127:0] s,
      input logic [127:0] a, input logic [5:0] im, input logic [1:0] ez,
      input logic ar, input logic ui);
    int w = 8 << ez;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [127:0] r = '0;
    for (int i = 0; i < 128 / w; i++) begin
      logic [63:0] x = 64'(s >> (i * w)) & mask;
      logic [63:0] ct = ui ? 64'(im) : (64'(a >> (i * w)) & mask);
      int sh = int'(ct % 64'(w));
      logic [63:0] y;
      if (sh == 0) y = x;
      else begin
        logic [63:0] xe = x;
        if (ar && x[w-1]) xe = x | ~mask;
        y = ar ? 64'($signed(xe) >>> sh) : (xe >> sh);
        y = (y + 64'(x[sh-1])) & mask;
      end
      r = r | (128'(y) << (i * w));
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act,
      input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [127:0] s,
      input logic [127:0] a, input logic [5:0] im, input logic [1:0] ez,
      input logic ar, input logic ui);
    logic [127:0] exp = model(s, a, im, ez, ar, ui);
    @(negedge clk);
    src_vec = s; amt_vec = a; imm_amt = im; esize = ez;
    arith = ar; use_imm = ui; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 128'(out_valid), 128'd1);
    check(req, res_vec, exp);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] rep(input logic [63:0] v, input int w);
    logic [127:0] r = '0;
    for (int i = 0; i < 128 / w; i++) r = r | (128'(v) << (i * w));
    return r;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R9: outputs cleared under reset
    check("R9 valid", 128'(out_valid), 128'd0);
    check("R9", res_vec, '0);
    rst = 1'b0;

    // R6 / R5: single-element examples, byte lanes
    run("R6 arith -1 sh1", 128'hFF, '0, 6'd1, 2'd0, 1'b1, 1'b1);
    check("R6 byte0 is 0", 128'(res_vec[7:0]), 128'h00);
    run("R5 0xFF sh1", 128'hFF, '0, 6'd1, 2'd0, 1'b0, 1'b1);
    check("R5 byte0 is 80", 128'(res_vec[7:0]), 128'h80);

    // R1: distinct per-lane values land in their own lanes
    run("R1 lanes", 128'h0F0E0D0C0B0A09080706050403020100, '0, 6'd1, 2'd0, 1'b0, 1'b1);
    check("R1 byte15", 128'(res_vec[127:120]), 128'h08);

    for (int ez = 0; ez < 4; ez++) begin
      int w = 8 << ez;
      logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 1);
      logic [63:0] minv = 64'd1 << (w - 1);
      for (int ar = 0; ar < 2; ar++) begin
        // R4: zero count passes the element unchanged
        run("R4 zero", rnd128(), '0, 6'd0, 2'(ez), 1'(ar), 1'b1);
        // R5: shift by W-1 on all-ones and minimum signed value
        run("R5 all-ones w-1", rep(msk, w), '0, 6'(w - 1), 2'(ez), 1'(ar), 1'b1);
        run("R6 min w-1", rep(minv, w), rep(64'(w - 1), w), 6'd0, 2'(ez), 1'(ar), 1'b0);
        run("R6 min sh1", rep(minv, w), '0, 6'd1, 2'(ez), 1'(ar), 1'b1);
        // R2: count elements with high bits set reduce modulo W
        run("R2 modulo", rnd128(), rep(msk & ~64'(w - 1) | 64'd3, w), 6'd0,
            2'(ez), 1'(ar), 1'b0);
        // R3: unused immediate bits ignored
        run("R3 imm upper", rnd128(), '0, 6'h3F & ~6'(w - 1) | 6'd2, 2'(ez), 1'(ar), 1'b1);
      end
    end

    // R5 / R2 / R3: seeded random mix
    for (int k = 0; k < 400; k++) begin
      logic [1:0] ez = 2'($urandom);
      logic ui = 1'($urandom);
      run(ui ? "R3 random" : "R2 random", rnd128(), rnd128(), 6'($urandom),
          ez, 1'($urandom), ui);
    end

    // R7 / R8: idle cycle drops valid and keeps the result
    begin
      logic [127:0] held;
      run("R7", rnd128(), rnd128(), 6'd5, 2'd2, 1'b1, 1'b0);
      held = res_vec;
      src_vec = rnd128(); amt_vec = rnd128(); imm_amt = 6'd9;
      @(negedge clk);
      check("R7 idle valid", 128'(out_valid), 128'd0);
      check("R8 hold", res_vec, held);
    end

    // R9: reset mid-run clears state
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R9 rerun", res_vec, '0);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule